// File: doc/BRIEF.md
# Windowed Limit Alert Monitor

The block watches a stream of 12-bit conversion results. Each result carries a 3-bit channel identifier. Channel IDs 0 to 3 stand for the first four inputs, and each of these has its own upper limit, lower limit and hysteresis margin. When a result leaves the window, that channel's alert is latched. The alert stays latched until a later result comes back inside the window by at least the hysteresis margin, or until software issues a clear command. Channel IDs 4 to 7 are passed through and never raise an alert.

For every accepted result the block produces a 16-bit report word, one cycle later. The word packs a global alert flag, the channel ID and the value. A combined alert output follows the OR of all channel alerts with one cycle of delay. The limit and margin registers are loaded through a plain write port, and they can be read back combinationally. A build parameter selects a 10-bit variant, in which the two lowest value bits are forced to zero before comparison and reporting.

Top module: `limit_alert_monitor`

## Requirements
- R1: For a result accepted with `res_valid` high, `out_valid` is high on the next cycle. `out_word` then holds bit 15 = alert flag, bits 14:12 = `res_chan`, and bits 11:0 = the value.
- R2: With `RES_BITS` = 10, bits 1:0 of the value are cleared before comparison and reporting, so `out_word[1:0]` reads as 0.
- R3: Results with channel ID 4 to 7 never set, clear or hold any channel alert.
- R4: After reset, every upper limit reads 0x0FFF, every lower limit and every margin reads 0, no channel alert is set, and `alert_o` is 0.
- R5: A result for channel c sets its alert when the value is strictly above the upper limit of c or strictly below its lower limit. A value equal to either limit does not set it.
- R6: An alert set by the upper limit clears only when a later in-window result satisfies value + margin <= upper, with no wrap-around. Any other in-window result keeps the alert.
- R7: An alert set by the lower limit clears only when a later in-window result satisfies value >= lower + margin. Any other in-window result keeps the alert.
- R8: The flag in bit 15 is 1 when any channel alert is active after the reported result has been applied.
- R9: `clr_cmd` = 2'b11 clears all channel alerts. The values 2'b00, 2'b01 and 2'b10 have no effect.
- R10: Register map: write address 0..3 = upper limit of channels 0..3, 4..7 = lower limit, 8..11 = margin. Only `cfg_wdata[11:0]` is stored, and `rd_data[15:12]` reads 0. Writes to addresses 12..15 are ignored, and reads of those addresses return 0.
- R11: `alert_o` equals the OR of `chan_alert` one cycle earlier.
- R12: When a clear command and a violating result arrive in the same cycle, the violating channel's alert is set and all other channels are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result present this cycle |
| res_chan | input | 3 | Channel ID of the result |
| res_data | input | 12 | Conversion value |
| clr_cmd | input | 2 | Alert clear command bits (2'b11 = clear) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| out_valid | output | 1 | Report word valid |
| out_word | output | 16 | Report word: flag, channel ID, value |
| chan_alert | output | 4 | Per-channel latched alert |
| alert_o | output | 1 | Combined alert, one cycle behind `chan_alert` |

## Verification
The clear command and a limit check on a new result can land on the same clock edge, and the rule is that the fresh violation wins. The bench forces this collision on a chosen channel while other channels hold alerts. It then expects exactly the violating channel to remain set and the report flag to agree. Random runs also place clear codes next to results that sit near the limits, so the collision occurs many more times, with every clear code value. A reference model in the bench predicts each of these cases.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int unsigned VAL_W  = 12;
  localparam int unsigned CH_W   = 3;
  localparam int unsigned WORD_W = 1 + CH_W + VAL_W;

  typedef enum logic [1:0] {
    AL_NONE = 2'd0,
    AL_HIGH = 2'd1,
    AL_LOW  = 2'd2
  } al_state_e;

  function automatic logic over_upper(input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] hi);
    return v > hi;
  endfunction

  function automatic logic under_lower(input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] lo);
    return v < lo;
  endfunction

  // value sits at least n below the upper limit, computed without wrap
  function automatic logic high_released(input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] hi,
                                         input logic [VAL_W-1:0] n);
    return ({1'b0, v} + {1'b0, n}) <= {1'b0, hi};
  endfunction

  // value sits at least n above the lower limit, computed without wrap
  function automatic logic low_released(input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] lo,
                                        input logic [VAL_W-1:0] n);
    return {1'b0, v} >= ({1'b0, lo} + {1'b0, n});
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic flag, input logic [CH_W-1:0] ch,
                                                  input logic [VAL_W-1:0] v);
    return {flag, ch, v};
  endfunction
endpackage

// File: rtl/lam_limit_regs.sv
module lam_limit_regs #(
  parameter int unsigned N_LIM  = 4,
  parameter int unsigned VAL_W  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned REG_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [REG_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [REG_W-1:0]             rd_data,
  output logic [N_LIM-1:0][VAL_W-1:0]  upper,
  output logic [N_LIM-1:0][VAL_W-1:0]  lower,
  output logic [N_LIM-1:0][VAL_W-1:0]  margin
);
  localparam int unsigned LO_BASE = N_LIM;
  localparam int unsigned HY_BASE = 2 * N_LIM;

  for (genvar g = 0; g < N_LIM; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        upper[g]  <= '1;
        lower[g]  <= '0;
        margin[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(g))           upper[g]  <= wr_data[VAL_W-1:0];
        if (wr_addr == ADDR_W'(LO_BASE + g)) lower[g]  <= wr_data[VAL_W-1:0];
        if (wr_addr == ADDR_W'(HY_BASE + g)) margin[g] <= wr_data[VAL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_LIM; i++) begin
      if (rd_addr == ADDR_W'(i))           rd_data[VAL_W-1:0] = upper[i];
      if (rd_addr == ADDR_W'(LO_BASE + i)) rd_data[VAL_W-1:0] = lower[i];
      if (rd_addr == ADDR_W'(HY_BASE + i)) rd_data[VAL_W-1:0] = margin[i];
    end
  end
endmodule

// File: rtl/lam_chan_fsm.sv
module lam_chan_fsm
  import lam_pkg::*;
#(
  parameter int unsigned VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [VW-1:0] val,
  input  logic [VW-1:0] upper,
  input  logic [VW-1:0] lower,
  input  logic [VW-1:0] margin,
  input  logic          clr,
  output logic          alert,
  output logic          nxt_alert,
  output logic          viol,
  output logic          release_ev
);
  al_state_e state_q, state_d;
  logic viol_hi, viol_lo;

  always_comb begin
    viol_hi    = hit && over_upper(val, upper);
    viol_lo    = hit && !viol_hi && under_lower(val, lower);
    release_ev = hit && !viol_hi && !viol_lo &&
                 (((state_q == AL_HIGH) && high_released(val, upper, margin)) ||
                  ((state_q == AL_LOW)  && low_released(val, lower, margin)));
    state_d = state_q;
    if (clr || release_ev) state_d = AL_NONE;
    if (viol_hi)           state_d = AL_HIGH;
    if (viol_lo)           state_d = AL_LOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= AL_NONE;
    else        state_q <= state_d;
  end

  assign viol      = viol_hi || viol_lo;
  assign alert     = (state_q != AL_NONE);
  assign nxt_alert = (state_d != AL_NONE);
endmodule

// File: rtl/limit_alert_monitor.sv
module limit_alert_monitor
  import lam_pkg::*;
#(
  parameter int unsigned N_LIM    = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned RES_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [VAL_W-1:0]  res_data,
  input  logic [1:0]        clr_cmd,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [N_LIM-1:0]  chan_alert,
  output logic              alert_o
);
  localparam int unsigned DROP = VAL_W - RES_BITS;
  localparam logic [VAL_W-1:0] LSB_MASK = VAL_W'((1 << DROP) - 1);
  localparam logic [1:0] CLR_CODE = 2'b11;

  logic [N_LIM-1:0][VAL_W-1:0] upper, lower, margin;
  logic [VAL_W-1:0] val_m;
  logic             clr_hit;
  logic [N_LIM-1:0] nxt_alert, viol, release_ev;

  assign val_m   = res_data & ~LSB_MASK;
  assign clr_hit = (clr_cmd == CLR_CODE);

  lam_limit_regs #(.N_LIM(N_LIM), .VAL_W(VAL_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .upper(upper), .lower(lower), .margin(margin)
  );

  for (genvar c = 0; c < N_LIM; c++) begin : g_ch
    lam_chan_fsm #(.VW(VAL_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .hit(res_valid && (res_chan == CH_W'(c))),
      .val(val_m), .upper(upper[c]), .lower(lower[c]), .margin(margin[c]),
      .clr(clr_hit),
      .alert(chan_alert[c]), .nxt_alert(nxt_alert[c]),
      .viol(viol[c]), .release_ev(release_ev[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      alert_o   <= 1'b0;
    end else begin
      out_valid <= res_valid;
      if (res_valid) out_word <= pack_word(|nxt_alert, res_chan, val_m);
      alert_o <= |chan_alert;
    end
  end
endmodule

// File: rtl/lam_checker.sv
module lam_checker #(
  parameter int unsigned N_LIM = 4,
  parameter int unsigned CH_W  = 3,
  parameter int unsigned DROP  = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic [CH_W-1:0]  res_chan,
  input logic             clr_hit,
  input logic [N_LIM-1:0] viol,
  input logic [N_LIM-1:0] chan_alert,
  input logic             alert_o,
  input logic             out_valid,
  input logic [15:0]      out_word
);
  a_r1_word_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (out_valid && out_word[14:12] == $past(res_chan)));

  a_r3_upper_ids_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_chan >= CH_W'(N_LIM) && !clr_hit) |=> $stable(chan_alert));

  a_r5_violation_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (viol != '0) |=> ((chan_alert & $past(viol)) == $past(viol)));

  a_r8_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[15] == (|chan_alert)));

  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && viol == '0) |=> (chan_alert == '0));

  a_r11_alert_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alert_o == $past(|chan_alert)));

  a_r12_violation_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (chan_alert == $past(viol)));

  if (DROP > 0) begin : g_low_bits
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word[DROP-1:0] == '0));
  end
endmodule

bind limit_alert_monitor lam_checker #(.N_LIM(N_LIM), .CH_W(lam_pkg::CH_W), .DROP(DROP)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan), .clr_hit(clr_hit),
  .viol(viol), .chan_alert(chan_alert), .alert_o(alert_o), .out_valid(out_valid),
  .out_word(out_word)
);

// File: tb/tb_limit_alert_monitor.sv
module tb_limit_alert_monitor;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, res_valid, cfg_we;
  logic [2:0]  res_chan;
  logic [11:0] res_data;
  logic [1:0]  clr_cmd;
  logic [3:0]  cfg_addr, rd_addr;
  logic [15:0] cfg_wdata, rd_data, out_word, out_word10, rd_data10;
  logic        out_valid, alert_o, out_valid10, alert_o10;
  logic [3:0]  chan_alert, chan_alert10;

  limit_alert_monitor dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .clr_cmd(clr_cmd), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid), .out_word(out_word),
    .chan_alert(chan_alert), .alert_o(alert_o));

  limit_alert_monitor #(.RES_BITS(10)) dut10 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .clr_cmd(clr_cmd), .cfg_we(1'b0), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data10), .out_valid(out_valid10), .out_word(out_word10),
    .chan_alert(chan_alert10), .alert_o(alert_o10));

  int mhi[4], mlo[4], mhy[4], mst[4]; // state: 0 none, 1 high, 2 low
  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_alerts();
    logic [3:0] a;
    for (int i = 0; i < 4; i++) a[i] = (mst[i] != 0);
    return a;
  endfunction

  function automatic void model_apply(input logic v, input int ch, input int d, input logic clr);
    for (int i = 0; i < 4; i++) begin
      if (clr) mst[i] = 0;
      if (v && ch == i) begin
        if (d > mhi[i])                              mst[i] = 1;
        else if (d < mlo[i])                         mst[i] = 2;
        else if (mst[i] == 1 && d + mhy[i] <= mhi[i]) mst[i] = 0;
        else if (mst[i] == 2 && d >= mlo[i] + mhy[i]) mst[i] = 0;
      end
    end
  endfunction

  task automatic step(input logic v, input int ch, input int d, input logic [1:0] cc,
                      input string tag);
    logic old_or;
    @(negedge clk);
    res_valid = v; res_chan = 3'(ch); res_data = 12'(d); clr_cmd = cc; cfg_we = 1'b0;
    old_or = |exp_alerts();
    @(posedge clk);
    model_apply(v, ch, d, cc == 2'b11);
    #2;
    chk({tag, " R11 alert_o"}, 32'(alert_o), 32'(old_or));
    chk({tag, " chan_alert"}, 32'(chan_alert), 32'(exp_alerts()));
    if (v) begin
      chk({tag, " R1/R8 word"}, 32'(out_word), {16'h0, |exp_alerts(), 3'(ch), 12'(d)});
      chk({tag, " R2 ten-bit value"}, 32'(out_word10[11:0]), 32'(12'(d) & 12'hFFC));
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    res_valid = 1'b0; clr_cmd = 2'b00; cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(posedge clk);
    if (a < 4) mhi[a] = d & 12'hFFF;
    else if (a < 8) mlo[a-4] = d & 12'hFFF;
    else if (a < 12) mhy[a-8] = d & 12'hFFF;
    #2;
  endtask

  task automatic rdchk(input int a, input int exp, input string tag);
    rd_addr = 4'(a);
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; res_valid = 1'b0; res_chan = '0; res_data = '0; clr_cmd = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_addr = '0;
    for (int i = 0; i < 4; i++) begin mhi[i] = 12'hFFF; mlo[i] = 0; mhy[i] = 0; mst[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R4 reset state
    chk("R4 alert_o", 32'(alert_o), 0);
    chk("R4 chan_alert", 32'(chan_alert), 0);
    chk("R4 out_valid", 32'(out_valid), 0);
    rdchk(2, 16'h0FFF, "R4 upper reset");
    rdchk(5, 0, "R4 lower reset");
    rdchk(11, 0, "R4 margin reset");

    // R10 register map
    wr(0, 16'hF800); rdchk(0, 16'h0800, "R10 upper store 12b");
    wr(4, 16'h0200); rdchk(4, 16'h0200, "R10 lower");
    wr(8, 16'hA010); rdchk(8, 16'h0010, "R10 margin");
    wr(12, 16'h0ABC); rdchk(12, 0, "R10 unmapped read");
    rdchk(0, 16'h0800, "R10 unmapped write ignored");
    wr(1, 16'h0100); wr(9, 16'h0200);

    // R5 boundaries and R6 upper release
    step(1, 0, 12'h800, 2'b00, "R5 equal upper");
    step(1, 0, 12'h801, 2'b00, "R5 above upper");
    step(1, 0, 12'h7F1, 2'b00, "R6 hold short of margin");
    step(1, 0, 12'h7F0, 2'b00, "R6 release at margin");
    // R7 lower
    step(1, 0, 12'h200, 2'b00, "R5 equal lower");
    step(1, 0, 12'h1FF, 2'b00, "R7 below lower");
    step(1, 0, 12'h20F, 2'b00, "R7 hold short of margin");
    step(1, 0, 12'h210, 2'b00, "R7 release at margin");
    // R6 margin larger than limit: no release
    step(1, 1, 12'h101, 2'b00, "R6 set ch1");
    step(1, 1, 12'h000, 2'b00, "R6 no wrap release");
    // R3 upper IDs
    step(1, 5, 12'hFFF, 2'b00, "R3 id5 high");
    step(1, 7, 12'h000, 2'b00, "R3 id7 low");
    // R8 flag on a different channel
    step(1, 6, 12'h123, 2'b00, "R8 flag from other channel");
    // R9 clear codes
    step(0, 0, 0, 2'b01, "R9 code 01 ignored");
    step(0, 0, 0, 2'b10, "R9 code 10 ignored");
    step(0, 0, 0, 2'b11, "R9 clear");
    // R12 clear together with violation
    step(1, 1, 12'h200, 2'b00, "R12 prime ch1");
    step(1, 0, 12'h900, 2'b00, "R12 prime ch0");
    step(1, 2, 12'h000, 2'b11, "R12 no violation ch2 clear");
    step(1, 0, 12'h100, 2'b00, "R12 prime ch0 low");
    step(1, 1, 12'h300, 2'b11, "R12 violation wins");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int ch, d, r, base;
      logic [1:0] cc;
      if ($urandom % 50 == 0) begin
        wr($urandom % 12, $urandom % 65536);
        continue;
      end
      ch = $urandom % 8;
      r = $urandom % 4;
      base = (ch < 4) ? ((r == 1) ? mhi[ch] : mlo[ch]) : 2048;
      if (r == 0) d = $urandom % 4096;
      else d = base + int'($urandom % 64) - 32;
      if (d < 0) d = 0;
      if (d > 4095) d = 4095;
      cc = ($urandom % 30 == 0) ? 2'b11 : (($urandom % 10 == 0) ? 2'($urandom % 3) : 2'b00);
      step($urandom % 8 != 0, ch, d, cc, "RND R5/R6/R7/R12");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule